// File: doc/BRIEF.md
# Programmable-Timeout Watchdog Timer

This block is the watchdog of a small microcontroller. It counts machine-cycle ticks. If software does not service it before the selected timeout, it raises a reset request for one clock. A 3-bit select field picks one of eight timeouts. Each timeout is a power of two minus one, starting at 2^BASE_EXP − 1 ticks and doubling with each step of the select value. With the default BASE_EXP of 14, the timeouts run from 16383 to 2097151 ticks.

Operating modes are tracked by a small state machine. It has five states:

- `WD_OFF`: the watchdog is disabled.
- `WD_RUN`: counting.
- `WD_IDLE`: counting while the core idles.
- `WD_HALT`: power-down, with the count frozen.
- `WD_WAKE`: power-down has ended, but the wake-interrupt line is still low, so the count stays frozen.

The transitions between states are:

- `en_on`: `WD_OFF` goes to `WD_RUN`, `WD_IDLE` or `WD_HALT`, as the mode inputs select.
- `en_off`: any state goes to `WD_OFF`.
- `pd_enter`: `WD_RUN`, `WD_IDLE` or `WD_WAKE` goes to `WD_HALT`.
- `pd_exit_low`: `WD_HALT` goes to `WD_WAKE`.
- `pd_exit_high`: `WD_HALT` goes to `WD_RUN` or `WD_IDLE`.
- `wake_release`: `WD_WAKE` goes to `WD_RUN` or `WD_IDLE`.
- `idle_toggle`: moves between `WD_RUN` and `WD_IDLE`.

When the wake line rises, counting resumes from the value that was held.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the select value is 0, the state is `WD_OFF`, the count is 0, and `wdt_rst` is low.
- R2: For select value n, written through `sel_wr_data[2:0]`, the timeout is 2^(BASE_EXP+n) − 1 counted ticks. `wdt_rst` rises in the cycle after the clock edge that samples the final tick.
- R3: The count advances only on edges where `tick_en` is high.
- R4: `wdt_rst` is high for exactly one clock. When it fires, the count restarts from zero, so an unserviced watchdog fires again every timeout.
- R5: A `kick` clears the count at the next edge. A kick on the same edge as the final tick suppresses that pulse.
- R6: A write that changes the select value clears the count, and the new timeout applies from zero. Writing the value already held leaves the count untouched.
- R7: While `wdt_en` is low, the count is held at 0 and `wdt_rst` stays low.
- R8: While `pd_mode` is high, the count does not advance.
- R9: If `pd_mode` falls while `wake_n` is low, the count stays frozen until `wake_n` goes high. Counting then resumes from the held value.
- R10: `idle_mode` does not change counting, so an unserviced watchdog still fires during idle.
- R11: If `pd_mode` falls while `wake_n` is high, counting resumes on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| tick_en | input | 1 | Machine-cycle enable, one per counted tick |
| sel_wr_en | input | 1 | Write strobe for the timeout select |
| sel_wr_data | input | SEL_W | New timeout select value |
| kick | input | 1 | Service strobe that restarts the count |
| wdt_en | input | 1 | Watchdog enable |
| pd_mode | input | 1 | Power-down mode active |
| idle_mode | input | 1 | Idle mode active |
| wake_n | input | 1 | Level of the external wake interrupt, active low |
| wdt_rst | output | 1 | One-clock reset request |

## Verification
Two functions can land on the same edge: expiry on the final tick, and a clear caused by either a kick or a select change. Both clears must win, so that no pulse appears.

A directed case times a kick onto exactly the edge that would expire a 15-tick timeout. It then expects silence for that edge and a full fresh period afterwards. The random phase drives ticks, kicks, select writes and mode changes with a short base exponent, so that these collisions recur many times. Every cycle is compared against a bench model of the requirements.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [2:0] {
        WD_OFF,
        WD_RUN,
        WD_IDLE,
        WD_HALT,
        WD_WAKE
    } wd_state_e;
endpackage

// File: rtl/wdog_mode_fsm.sv
module wdog_mode_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      pd,
    input  logic      idle,
    input  logic      wake_n,
    output wd_state_e state_q,
    output logic      cnt_go
);
    wd_state_e state_d;
    wd_state_e live_st;

    assign live_st = idle ? WD_IDLE : WD_RUN;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF: begin
                if (en) state_d = pd ? WD_HALT : live_st;
            end
            WD_RUN, WD_IDLE: begin
                if (!en)     state_d = WD_OFF;
                else if (pd) state_d = WD_HALT;
                else         state_d = live_st;
            end
            WD_HALT: begin
                if (!en)     state_d = WD_OFF;
                else if (!pd) state_d = wake_n ? live_st : WD_WAKE;
            end
            WD_WAKE: begin
                if (!en)         state_d = WD_OFF;
                else if (pd)     state_d = WD_HALT;
                else if (wake_n) state_d = live_st;
            end
            default: state_d = WD_OFF;
        endcase
    end

    always_comb begin
        unique case (state_q)
            WD_RUN, WD_IDLE: cnt_go = en;
            default:         cnt_go = 1'b0;
        endcase
    end
endmodule

// File: rtl/wdog_sel_reg.sv
module wdog_sel_reg #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_data,
    output logic [SEL_W-1:0] sel_q,
    output logic             sel_chg
);
    assign sel_chg = wr_en && (wr_data != sel_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sel_q <= '0;
        else if (wr_en)   sel_q <= wr_data;
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int BASE_EXP = 14,
    parameter int SEL_W    = 3,
    parameter int CNT_W    = BASE_EXP + (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             kick,
    input  logic             sel_chg,
    input  logic             cnt_go,
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fire_q
);
    localparam int NSEL = 1 << SEL_W;

    logic [CNT_W-1:0] last_tab [NSEL];
    logic [CNT_W-1:0] last_step;
    logic             clr;

    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_term
            localparam logic [CNT_W:0] ONE_HOT = (CNT_W+1)'(1) << (BASE_EXP + g);
            assign last_tab[g] = CNT_W'(ONE_HOT - (CNT_W+1)'(2));
        end
    endgenerate

    assign last_step = last_tab[sel];
    assign clr       = kick || sel_chg || !en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
            end else if (cnt_go && tick) begin
                if (cnt_q == last_step) begin
                    cnt_q  <= '0;
                    fire_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int BASE_EXP = 14,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             sel_wr_en,
    input  logic [SEL_W-1:0] sel_wr_data,
    input  logic             kick,
    input  logic             wdt_en,
    input  logic             pd_mode,
    input  logic             idle_mode,
    input  logic             wake_n,
    output logic             wdt_rst
);
    localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1;

    wd_state_e        state_q;
    logic             cnt_go;
    logic [SEL_W-1:0] sel_q;
    logic             sel_chg;
    logic [CNT_W-1:0] cnt_q;

    wdog_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (wdt_en),
        .pd      (pd_mode),
        .idle    (idle_mode),
        .wake_n  (wake_n),
        .state_q (state_q),
        .cnt_go  (cnt_go)
    );

    wdog_sel_reg #(.SEL_W(SEL_W)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_wr_en),
        .wr_data (sel_wr_data),
        .sel_q   (sel_q),
        .sel_chg (sel_chg)
    );

    wdog_counter #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (wdt_en),
        .tick    (tick_en),
        .kick    (kick),
        .sel_chg (sel_chg),
        .cnt_go  (cnt_go),
        .sel     (sel_q),
        .cnt_q   (cnt_q),
        .fire_q  (wdt_rst)
    );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             sel_wr_en,
    input logic             kick,
    input logic             wdt_en,
    input logic             pd_mode,
    input logic             wake_n,
    input logic             wdt_rst,
    input wd_state_e        state_q,
    input logic [CNT_W-1:0] cnt_q
);
    assert_fire_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> $past(tick_en));

    assert_tick_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !kick && !sel_wr_en && wdt_en) |=> $stable(cnt_q));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    assert_kick_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt_q == '0 && !wdt_rst));

    assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en |=> (cnt_q == '0 && !wdt_rst));

    assert_halt_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_HALT && wdt_en && !kick && !sel_wr_en) |=> $stable(cnt_q));

    assert_wake_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_WAKE && wdt_en && !pd_mode && !wake_n && !kick && !sel_wr_en)
        |=> ($stable(cnt_q) && state_q == WD_WAKE));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .sel_wr_en (sel_wr_en),
    .kick      (kick),
    .wdt_en    (wdt_en),
    .pd_mode   (pd_mode),
    .wake_n    (wake_n),
    .wdt_rst   (wdt_rst),
    .state_q   (state_q),
    .cnt_q     (cnt_q)
);

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
    localparam int BASE = 4;
    localparam int SW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          sel_wr_en = 1'b0;
    logic [SW-1:0] sel_wr_data = '0;
    logic          kick = 1'b0;
    logic          wdt_en = 1'b0;
    logic          pd_mode = 1'b0;
    logic          idle_mode = 1'b0;
    logic          wake_n = 1'b1;
    logic          wdt_rst;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    int m_st = 0, m_cnt = 0, m_sel = 0;
    bit m_fire = 1'b0;

    always #10 clk = ~clk;

    wdog_timer #(.BASE_EXP(BASE), .SEL_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sel_wr_en(sel_wr_en),
        .sel_wr_data(sel_wr_data), .kick(kick), .wdt_en(wdt_en), .pd_mode(pd_mode),
        .idle_mode(idle_mode), .wake_n(wake_n), .wdt_rst(wdt_rst)
    );

    function automatic int term(input int s);
        return (1 << (BASE + s)) - 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Requirement model: states 0 off, 1 counting, 2 halted, 3 wake hold
    always @(posedge clk) begin
        int nc, ns;
        bit nf;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_sel = 0; m_fire = 1'b0;
        end else begin
            nf = 1'b0;
            if (kick || (sel_wr_en && int'(sel_wr_data) != m_sel) || !wdt_en) nc = 0;
            else if (m_st == 1 && tick_en) begin
                if (m_cnt == term(m_sel) - 1) begin nc = 0; nf = 1'b1; end
                else nc = m_cnt + 1;
            end else nc = m_cnt;
            if (!wdt_en) ns = 0;
            else if (pd_mode) ns = 2;
            else if (m_st == 0 || m_st == 1) ns = 1;
            else ns = wake_n ? 1 : 3;
            if (sel_wr_en) m_sel = int'(sel_wr_data);
            m_cnt = nc; m_fire = nf; m_st = ns;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) chk(wdt_rst === m_fire, cur_req, int'(wdt_rst), int'(m_fire));
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (wdt_rst !== 1'b1 && n < 5000);
    endtask

    task automatic write_sel(input int v);
        sel_wr_en = 1'b1; sel_wr_data = SW'(v);
        @(negedge clk);
        sel_wr_en = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #4000000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n, pulses;
        void'($urandom(32'd20240611));
        // R1: reset state
        step(3);
        chk(wdt_rst === 1'b0, "R1", int'(wdt_rst), 0);
        rst_n = 1'b1;
        step(2);
        // R1/R2: default select is 0 -> 15 ticks, pulse 16 negedges after enable
        cur_req = "R2";
        tick_en = 1'b1; wdt_en = 1'b1;
        wait_pulse(n);
        chk(n == term(0) + 1, "R1 default timeout", n, term(0) + 1);
        // R4: periodic, one clock wide
        cur_req = "R4";
        wait_pulse(n);
        chk(n == term(0), "R4 period", n, term(0));
        @(negedge clk);
        chk(wdt_rst === 1'b0, "R4 width", int'(wdt_rst), 0);
        // R6: changing select restarts, new timeout 63
        cur_req = "R6";
        write_sel(2);
        wait_pulse(n);
        chk(n == term(2), "R6 new timeout", n, term(2));
        step(5);
        write_sel(2);       // same value: no clear
        wait_pulse(n);
        chk(n == term(2) - 6, "R6 same value", n, term(2) - 6);
        write_sel(0);
        wait_pulse(n);
        // R5: kick on the final tick suppresses the pulse
        cur_req = "R5";
        step(term(0) - 1);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        chk(wdt_rst === 1'b0, "R5 collision", int'(wdt_rst), 0);
        wait_pulse(n);
        chk(n == term(0), "R5 fresh period", n, term(0));
        // R3: ticks every other cycle double the wall time
        cur_req = "R3";
        for (int i = 0; i < 2 * term(0) + 4; i++) begin
            tick_en = i[0];
            @(negedge clk);
            if (wdt_rst) break;
        end
        tick_en = 1'b1;
        // R7: disabled holds zero, no pulse
        cur_req = "R7";
        wdt_en = 1'b0;
        pulses = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (wdt_rst) pulses++; end
        chk(pulses == 0, "R7 disabled", pulses, 0);
        wdt_en = 1'b1;
        wait_pulse(n);
        chk(n == term(0) + 1, "R7 restart from zero", n, term(0) + 1);
        // R8: power-down freezes
        cur_req = "R8";
        step(5);
        pd_mode = 1'b1;
        pulses = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (wdt_rst) pulses++; end
        chk(pulses == 0, "R8 frozen", pulses, 0);
        // R9: wake line low holds count
        cur_req = "R9";
        wake_n = 1'b0; pd_mode = 1'b0;
        pulses = 0;
        for (int i = 0; i < 50; i++) begin @(negedge clk); if (wdt_rst) pulses++; end
        chk(pulses == 0, "R9 held", pulses, 0);
        wake_n = 1'b1;
        wait_pulse(n);
        chk(n >= 2 && n <= term(0), "R9 resume", n, term(0));
        // R11: exit with wake high resumes immediately
        cur_req = "R11";
        step(3);
        pd_mode = 1'b1;
        step(20);
        pd_mode = 1'b0;
        wait_pulse(n);
        chk(n >= 2 && n <= term(0), "R11 resume", n, term(0));
        // R10: idle keeps counting
        cur_req = "R10";
        idle_mode = 1'b1;
        pulses = 0;
        for (int i = 0; i < 4 * term(0); i++) begin @(negedge clk); if (wdt_rst) pulses++; end
        chk(pulses >= 3, "R10 idle fires", pulses, 4);
        idle_mode = 1'b0;
        // Random phase with collisions, compared every cycle
        cur_req = "random R4";
        for (int i = 0; i < 20000; i++) begin
            tick_en   = ($urandom % 8) != 0;
            kick      = ($urandom % 40) == 0;
            sel_wr_en = ($urandom % 150) == 0;
            sel_wr_data = SW'($urandom % 3);
            if (($urandom % 300) == 0) wdt_en = ~wdt_en;
            if (!wdt_en && ($urandom % 20) == 0) wdt_en = 1'b1;
            if (($urandom % 200) == 0) pd_mode = ~pd_mode;
            if (($urandom % 30) == 0) wake_n = ~wake_n;
            if (($urandom % 50) == 0) idle_mode = ~idle_mode;
            @(negedge clk);
        end
        finish_run();
    end
endmodule